// File: doc/BRIEF.md
# Queued Serial Transmitter

This block turns bytes written into a small internal queue into asynchronous serial frames on one output line. Each frame has a start bit, five to eight data bits sent least significant bit first, an optional even or odd parity bit and one or two stop bits. An external baud tick at sixteen times the bit rate times every bit.

The transmitter sends only while both the global enable and the transmit enable are high. Both are expected high out of reset. If either is dropped while a frame is on the line, that frame is finished and the line then stays idle. Queued bytes are kept until both enables are high again. Frame settings are captured when a frame starts, so changing them has no effect on the frame already being sent.

Top module: `uart_tx_core`

## Requirements
- R1: The idle line is high. A frame drives one low start bit, then the data bits with the least significant bit first, then the parity bit when enabled, then high stop bits.
- R2: Each bit of a frame is held for exactly 16 pulses of `baud_tick_i`.
- R3: `data_len_i` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only that many low-order bits of the queued byte are sent.
- R4: `parity_mode_i` 01 appends even parity and 10 appends odd parity. The parity is taken over the data bits that are actually sent. 00 and 11 send no parity bit.
- R5: `two_stop_i` high sends two stop bits and low sends one. With 8 data bits and no parity, the start of a frame follows the start of the previous frame in the same burst after 177 clocks with two stop bits and 161 with one, when `baud_tick_i` is high every cycle.
- R6: The queue holds 16 bytes, sends them in write order, and raises `full_o` when 16 are held.
- R7: A write while `full_o` is high is dropped.
- R8: A new frame starts only while `uart_en_i` and `tx_en_i` are both high.
- R9: Clearing either enable during a frame lets that frame complete unchanged before the line stays idle.
- R10: While transmission is disabled the queue keeps its bytes. They are sent once both enables are high again.
- R11: `busy_o` is high while a frame is on the line, or while the queue is not empty and both enables are high. Otherwise it is low.
- R12: After reset `tx_o` is high and `full_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the queue |
| wr_data_i | input | 8 | Byte to queue |
| full_o | output | 1 | Queue holds 16 bytes |
| baud_tick_i | input | 1 | Pulse at 16x the bit rate |
| data_len_i | input | 2 | Data length select |
| parity_mode_i | input | 2 | Parity select |
| two_stop_i | input | 1 | Two stop bits when high |
| uart_en_i | input | 1 | Global enable |
| tx_en_i | input | 1 | Transmit enable |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress or work pending |

## Verification
The line-hold assertion takes for granted that `baud_tick_i` is the only thing that advances a bit. It lets the line change only after a tick or when a frame starts from idle. The stimulus therefore keeps the tick a single-cycle pulse, at every cycle or at every third cycle, and never stalls it during a frame. The assertions also assume that configuration changes and enable changes arrive as clean levels away from the clock edge. The bench drives all inputs on the falling edge and changes settings only while the line is idle, except for the enable drops that are being tested.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic       two_stop;
  } frame_cfg_t;

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < 5 + int'(len));
    return m;
  endfunction

  function automatic logic parity_on(input logic [1:0] par);
    return par[0] ^ par[1];
  endfunction

  // even: bit makes total ones even; odd: inverted
  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] par);
    return par[1] ? ~(^d) : (^d);
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          wr_ok, rd_ok;

  assign full_o    = (count_q == CW'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign wr_ok     = wr_en_i && !full_o;
  assign rd_ok     = rd_en_i && !empty_o;
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o); // R6

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> (full_o && $stable(wr_ptr_q))); // R7

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  frame_cfg_t cfg_i,
  input  logic       en_i,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       tx_o,
  output logic       active_o
);
  localparam int TW = $clog2(OSR);

  tx_state_e  state_q;
  frame_cfg_t cfg_q;
  logic [TW-1:0] tick_cnt_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] shift_q;
  logic       par_q;
  logic       stop_cnt_q;
  logic       start, bit_done, last_data;
  logic       past_valid_q;

  assign start     = (state_q == ST_IDLE) && en_i && avail_i;
  assign pop_o     = start;
  assign bit_done  = baud_tick_i && (tick_cnt_q == TW'(OSR - 1));
  assign last_data = (bit_cnt_q == (3'(cfg_q.len) + 3'd4));
  assign active_o  = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = shift_q[0];
      ST_PARITY: tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      tick_cnt_q <= '0;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      par_q      <= 1'b0;
      stop_cnt_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start) begin
        state_q    <= ST_START;
        cfg_q      <= cfg_i;
        shift_q    <= data_i & len_mask(cfg_i.len);
        par_q      <= parity_bit(data_i & len_mask(cfg_i.len), cfg_i.par);
        tick_cnt_q <= '0;
        bit_cnt_q  <= '0;
        stop_cnt_q <= 1'b0;
      end
    end else begin
      if (baud_tick_i) tick_cnt_q <= bit_done ? '0 : tick_cnt_q + 1'b1;
      if (bit_done) begin
        case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shift_q   <= shift_q >> 1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (last_data) state_q <= parity_on(cfg_q.par) ? ST_PARITY : ST_STOP;
          end
          ST_PARITY: state_q <= ST_STOP;
          ST_STOP: begin
            if (stop_cnt_q || !cfg_q.two_stop) state_q <= ST_IDLE;
            else stop_cnt_q <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && !$stable(tx_o)) |-> ($past(baud_tick_i) || $past(state_q == ST_IDLE))); // R2

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && state_q == ST_START && $past(state_q == ST_IDLE)) |-> $past(en_i)); // R8

  AST_DATA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (bit_cnt_q <= 3'(cfg_q.len) + 3'd4)); // R3

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       full_o,
  input  logic       baud_tick_i,
  input  logic [1:0] data_len_i,
  input  logic [1:0] parity_mode_i,
  input  logic       two_stop_i,
  input  logic       uart_en_i,
  input  logic       tx_en_i,
  output logic       tx_o,
  output logic       busy_o
);
  logic       en, empty, pop, active;
  logic [7:0] head;
  frame_cfg_t cfg;

  assign en  = uart_en_i && tx_en_i;
  assign cfg = '{len: data_len_i, par: parity_mode_i, two_stop: two_stop_i};

  uart_tx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (pop),
    .rd_data_o (head),
    .full_o    (full_o),
    .empty_o   (empty)
  );

  uart_tx_framer #(.OSR(OSR)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .baud_tick_i (baud_tick_i),
    .cfg_i       (cfg),
    .en_i        (en),
    .avail_i     (!empty),
    .data_i      (head),
    .pop_o       (pop),
    .tx_o        (tx_o),
    .active_o    (active)
  );

  assign busy_o = active || (!empty && en);

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R1

  AST_LOW_MEANS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_o |-> busy_o); // R11

endmodule

// File: tb/uart_tx_core_bench.sv
`timescale 1ns/1ps
module uart_tx_core_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       full, tx, busy;
  logic       baud_tick = 1'b0;
  logic [1:0] data_len = 2'b11;
  logic [1:0] par_mode = 2'b00;
  logic       two_stop = 1'b0;
  logic       uart_en = 1'b1;
  logic       tx_en = 1'b1;

  int errors = 0;
  int checks = 0;
  int tick_div = 1;
  int cyc = 0;

  always #2 clk = ~clk;

  uart_tx_core u_uart_tx_core (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full),
    .baud_tick_i(baud_tick), .data_len_i(data_len), .parity_mode_i(par_mode),
    .two_stop_i(two_stop), .uart_en_i(uart_en), .tx_en_i(tx_en), .tx_o(tx), .busy_o(busy)
  );

  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      cyc++;
      c = (c + 1 >= tick_div) ? 0 : c + 1;
      baud_tick = (c == 0);
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drop: 0 none, 1 clear tx_en, 2 clear uart_en once the start bit is seen
  task automatic recv(input int len, input int par, input bit two, input int drop,
                      output logic [7:0] d, output bit ok, output int t0);
    int n;
    logic pb;
    n = 0; ok = 1'b1; d = '0; t0 = 0;
    while (tx !== 1'b0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) begin
      ok = 1'b0;
      return;
    end
    t0 = cyc;
    if (drop == 1) tx_en = 1'b0;
    if (drop == 2) uart_en = 1'b0;
    repeat (8 * tick_div) @(negedge clk);
    if (tx !== 1'b0) ok = 1'b0;
    for (int i = 0; i < len; i++) begin
      repeat (16 * tick_div) @(negedge clk);
      d[i] = tx;
    end
    if (par == 1 || par == 2) begin
      repeat (16 * tick_div) @(negedge clk);
      pb = tx;
      if (pb !== ((par == 1) ? ^d : ~(^d))) ok = 1'b0;
    end
    repeat (16 * tick_div) @(negedge clk);
    if (tx !== 1'b1) ok = 1'b0;
    if (two) begin
      repeat (16 * tick_div) @(negedge clk);
      if (tx !== 1'b1) ok = 1'b0;
    end
  endtask

  task automatic t_reset();
    check_eq("R12", "tx after reset", int'(tx), 1);
    check_eq("R12", "full after reset", int'(full), 0);
    check_eq("R12", "busy after reset", int'(busy), 0);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    bit ok;
    int t;
    data_len = 2'b11; par_mode = 2'b00; two_stop = 1'b0;
    wr_byte(8'hA5);
    wr_byte(8'h3C);
    recv(8, 0, 1'b0, 0, d, ok, t);
    check_eq("R1", "first byte", int'(d), 'hA5);
    check_eq("R1", "first frame shape", int'(ok), 1);
    recv(8, 0, 1'b0, 0, d, ok, t);
    check_eq("R1", "second byte", int'(d), 'h3C);
    check_eq("R1", "second frame shape", int'(ok), 1);
  endtask

  task automatic t_lengths();
    logic [7:0] pat [4];
    logic [7:0] d;
    bit ok;
    int t;
    pat[0] = 8'hD5; pat[1] = 8'hA9; pat[2] = 8'h35; pat[3] = 8'h96;
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      data_len = 2'(l); par_mode = 2'b00; two_stop = 1'b0;
      wr_byte(pat[l]);
      recv(5 + l, 0, 1'b0, 0, d, ok, t);
      check_eq("R3", $sformatf("data len %0d", 5 + l), int'(d), int'(pat[l] & 8'((1 << (5 + l)) - 1)));
      check_eq("R3", $sformatf("stop after len %0d", 5 + l), int'(ok), 1);
    end
  endtask

  task automatic t_parity();
    logic [7:0] d;
    bit ok;
    int t;
    for (int p = 1; p < 4; p++) begin
      @(negedge clk);
      data_len = 2'b00; par_mode = 2'(p); two_stop = 1'b0;
      wr_byte(8'hE3);
      recv(5, p, 1'b0, 0, d, ok, t);
      check_eq("R4", $sformatf("parity mode %0d data", p), int'(d), 'h03);
      check_eq("R4", $sformatf("parity mode %0d bit and stop", p), int'(ok), 1);
    end
  endtask

  task automatic t_stops();
    logic [7:0] d;
    bit ok;
    int t1, t2;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      data_len = 2'b11; par_mode = 2'b00; two_stop = s[0];
      wr_byte(8'h00);
      wr_byte(8'h81);
      recv(8, 0, s[0], 0, d, ok, t1);
      check_eq("R5", "frame with stop setting", int'(ok), 1);
      recv(8, 0, s[0], 0, d, ok, t2);
      check_eq("R5", "second byte", int'(d), 'h81);
      check_eq("R5", "start-to-start clocks", t2 - t1, (s == 1) ? 177 : 161);
    end
    two_stop = 1'b0;
  endtask

  task automatic t_bit_time();
    int n;
    logic [7:0] d;
    bit ok;
    int t;
    @(negedge clk);
    tick_div = 3;
    data_len = 2'b11; par_mode = 2'b00; two_stop = 1'b0;
    wr_byte(8'h00);
    n = 0;
    while (tx !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    while (tx === 1'b0 && n < 2000) begin @(negedge clk); n++; end
    check_eq("R2", "low run in range", int'(n >= 143 * 3 + 1 && n <= 144 * 3), 1);
    repeat (40) @(negedge clk);
    wr_byte(8'h5A);
    recv(8, 0, 1'b0, 0, d, ok, t);
    check_eq("R2", "data at slow tick", int'(d), 'h5A);
    check_eq("R2", "frame at slow tick", int'(ok), 1);
    repeat (40) @(negedge clk);
    tick_div = 1;
  endtask

  task automatic t_full();
    logic [7:0] d;
    bit ok;
    int t;
    @(negedge clk);
    data_len = 2'b11; par_mode = 2'b00; two_stop = 1'b0;
    tx_en = 1'b0;
    for (int i = 0; i < 16; i++) wr_byte(8'(i * 7 + 1));
    check_eq("R6", "full at 16", int'(full), 1);
    check_eq("R11", "busy low while disabled", int'(busy), 0);
    wr_byte(8'hEE);
    repeat (200) @(negedge clk);
    check_eq("R10", "line idle while disabled", int'(tx), 1);
    @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    check_eq("R11", "busy after enable", int'(busy), 1);
    for (int i = 0; i < 16; i++) begin
      recv(8, 0, 1'b0, 0, d, ok, t);
      check_eq("R6", $sformatf("order entry %0d", i), int'(d), (i * 7 + 1) & 255);
      if (!ok) check_eq("R6", "frame shape", int'(ok), 1);
    end
    repeat (400) @(negedge clk);
    check_eq("R7", "no frame from dropped write", int'(tx), 1);
    check_eq("R7", "busy low after drain", int'(busy), 0);
  endtask

  task automatic t_mid_disable(input int which);
    logic [7:0] d;
    bit ok;
    int t;
    @(negedge clk);
    data_len = 2'b11; par_mode = 2'b10; two_stop = 1'b1;
    wr_byte(8'h6B);
    wr_byte(8'h2D);
    recv(8, 2, 1'b1, which, d, ok, t);
    check_eq("R9", $sformatf("frame finished, enable %0d cleared", which), int'(d), 'h6B);
    check_eq("R9", "completed frame shape", int'(ok), 1);
    repeat (20 * 16) @(negedge clk);
    check_eq("R8", "no new frame while disabled", int'(tx), 1);
    check_eq("R11", "busy low while disabled", int'(busy), 0);
    @(negedge clk);
    tx_en = 1'b1; uart_en = 1'b1;
    recv(8, 2, 1'b1, 0, d, ok, t);
    check_eq("R10", "kept byte after re-enable", int'(d), 'h2D);
    check_eq("R10", "kept byte frame shape", int'(ok), 1);
    par_mode = 2'b00; two_stop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stops();
    t_bit_time();
    t_full();
    t_mid_disable(1);
    t_mid_disable(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule